// File: doc/BRIEF.md
# IDE PIO Register Cycle Engine

This block runs one programmed-I/O register access at a time on a parallel IDE/ATA bus on behalf of a host-side requester. The requester presents a chip-select pair, a three-bit register address, a direction, a width request and write data, all qualified by a valid pulse. The engine takes the request only when it is idle. It then steps through a fixed sequence: it sets the data-bus direction, drives the address and chip selects, pulses the active-low read or write strobe, and holds the address afterwards. It finishes with a one-cycle done pulse. Read data is returned on a dedicated output.

The data bus is split into separate drive, enable and sample signals, with one enable for each byte lane, so the pad ring owns the actual tristate buffers. The bus can carry 16 bits only for the data register, which is chip-select pair `10` with address `000`. Every other register is moved on the low byte lane only. The setup, strobe and hold lengths are parameters counted in clock cycles.

The controller has six states. ST_IDLE leaves the bus quiet. Its transition ACCEPT goes to ST_TURN when a request is valid. ST_TURN sets the bus direction with the chip selects still high. Transition DIR_SET goes to ST_SETUP, where the address and chip selects are driven for SETUP_CLKS cycles. Transition SETUP_DONE goes to ST_STROBE, where the strobe is low for STROBE_CLKS cycles. Transition STROBE_DONE goes to ST_HOLD and captures read data. ST_HOLD keeps the address and data for HOLD_CLKS cycles. Transition HOLD_DONE goes to ST_DONE, which pulses done. Transition RETIRE goes back to ST_IDLE.

Top module: `ide_pio_engine`

## Requirements
- R1: While reset is asserted, and in idle, both strobes are high, both chip selects are high (`11`), both lane enables are low, and busy and done are low. Reset is asynchronous and aborts any access in progress.
- R2: A request is taken only in idle. A valid request presented while busy is ignored: it never reaches the bus and starts no later access.
- R3: In a read, neither lane enable is ever high. The chip selects and address are driven for SETUP_CLKS cycles before the read strobe falls. The write strobe stays high throughout.
- R4: In a write, the low lane enable is already high in the cycle before the chip selects assert. The write data is on the bus while the write strobe is low. The read strobe stays high throughout.
- R5: The active strobe stays low for exactly STROBE_CLKS consecutive cycles.
- R6: After the strobe rises, the chip selects, address and write data stay driven for HOLD_CLKS cycles. They are then released: chip selects return to `11` and the enables go low.
- R7: Read data is sampled on the clock edge that ends the last strobe-low cycle. A change on the bus after the strobe rises does not alter the result.
- R8: An 8-bit access uses only bits 7..0. On a write the high-lane enable stays low. On a read the result has bits 15..8 equal to zero.
- R9: A 16-bit access happens only when the width request is set and the select is the data register: chip-select pair `10` (bit 1 is the second select, bit 0 the first) with address `000`. A width request for any other register gives an 8-bit access.
- R10: Busy is high from the cycle after acceptance through the done cycle, which is 2+SETUP_CLKS+STROBE_CLKS+HOLD_CLKS cycles. Done is high for exactly the last of those cycles, and the read result is valid from that cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request qualifier, taken only when idle |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_wide | input | 1 | Request a 16-bit access |
| req_cs_n | input | 2 | Chip-select pair, active low; bit 0 first select, bit 1 second |
| req_addr | input | 3 | Register address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read result |
| ide_cs_n | output | 2 | Bus chip selects, active low |
| ide_addr | output | 3 | Bus register address |
| ide_rd_n | output | 1 | Read strobe, active low |
| ide_wr_n | output | 1 | Write strobe, active low |
| ide_dd_out | output | 16 | Data bus drive value |
| ide_dd_oe_lo | output | 1 | Drive enable for bits 7..0 |
| ide_dd_oe_hi | output | 1 | Drive enable for bits 15..8 |
| ide_dd_in | input | 16 | Data bus sampled value |

## Verification
With default parameters, acceptance happens on a rising edge. The direction cycle is then seen at the next falling edge. The chip selects appear one cycle later, and the strobe falls SETUP_CLKS cycles after that. Done and the read result are due on the eleventh falling edge after acceptance. The bench samples every output at falling edges and counts cycles from acceptance, so each timing check compares a measured cycle count with the parameter sum. The bench changes its read source exactly at the first falling edge after the strobe rises. That shows the capture happened on the edge that ended the strobe and not later.

// File: rtl/ide_pio_pkg.sv
package ide_pio_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TURN,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_DONE
    } pio_state_e;

    localparam logic [1:0] DATA_REG_CS_N = 2'b10;
    localparam logic [2:0] DATA_REG_ADDR = 3'b000;
    localparam logic [1:0] CS_IDLE       = 2'b11;

    function automatic logic wide_allowed(input logic       want_wide,
                                          input logic [1:0] cs_n,
                                          input logic [2:0] addr);
        return want_wide && (cs_n == DATA_REG_CS_N) && (addr == DATA_REG_ADDR);
    endfunction

endpackage

// File: rtl/ide_pio_timer.sv
module ide_pio_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/ide_pio_lanes.sv
module ide_pio_lanes #(
    parameter int DW = 16
) (
    input  logic          is_wide,
    input  logic          drive_en,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] bus_in,
    output logic [DW-1:0] bus_out,
    output logic          oe_lo,
    output logic          oe_hi,
    output logic [DW-1:0] rd_word
);

    localparam int HALF = DW / 2;

    always_comb begin
        oe_lo = drive_en;
        oe_hi = drive_en && is_wide;
        if (is_wide) begin
            bus_out = wdata;
            rd_word = bus_in;
        end else begin
            bus_out = {{HALF{1'b0}}, wdata[HALF-1:0]};
            rd_word = {{HALF{1'b0}}, bus_in[HALF-1:0]};
        end
    end

endmodule

// File: rtl/ide_pio_engine.sv
module ide_pio_engine
    import ide_pio_pkg::*;
#(
    parameter int DW          = 16,
    parameter int SETUP_CLKS  = 3,
    parameter int STROBE_CLKS = 4,
    parameter int HOLD_CLKS   = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          req_wide,
    input  logic [1:0]    req_cs_n,
    input  logic [2:0]    req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] rdata,
    output logic [1:0]    ide_cs_n,
    output logic [2:0]    ide_addr,
    output logic          ide_rd_n,
    output logic          ide_wr_n,
    output logic [DW-1:0] ide_dd_out,
    output logic          ide_dd_oe_lo,
    output logic          ide_dd_oe_hi,
    input  logic [DW-1:0] ide_dd_in
);

    localparam int MAX_A    = (SETUP_CLKS > STROBE_CLKS) ? SETUP_CLKS : STROBE_CLKS;
    localparam int MAX_CLKS = (MAX_A > HOLD_CLKS) ? MAX_A : HOLD_CLKS;
    localparam int CNT_W    = (MAX_CLKS > 1) ? $clog2(MAX_CLKS) : 1;
    localparam logic [CNT_W-1:0] SETUP_LD  = CNT_W'(SETUP_CLKS - 1);
    localparam logic [CNT_W-1:0] STROBE_LD = CNT_W'(STROBE_CLKS - 1);
    localparam logic [CNT_W-1:0] HOLD_LD   = CNT_W'(HOLD_CLKS - 1);

    pio_state_e state_q, state_d;

    logic          lat_write_q;
    logic          lat_wide_q;
    logic [1:0]    lat_cs_n_q;
    logic [2:0]    lat_addr_q;
    logic [DW-1:0] lat_wdata_q;
    logic [DW-1:0] rdata_q;

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             drive_en;
    logic             addr_en;
    logic             accept;
    logic             capture;
    logic [DW-1:0]    rd_word;

    assign accept  = (state_q == ST_IDLE) && req_valid;
    assign capture = (state_q == ST_STROBE) && tmr_expired;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and timer loading
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) state_d = ST_TURN;
            end
            ST_TURN: begin
                state_d  = ST_SETUP;
                tmr_load = 1'b1;
                tmr_val  = SETUP_LD;
            end
            ST_SETUP: begin
                if (tmr_expired) begin
                    state_d  = ST_STROBE;
                    tmr_load = 1'b1;
                    tmr_val  = STROBE_LD;
                end
            end
            ST_STROBE: begin
                if (tmr_expired) begin
                    state_d  = ST_HOLD;
                    tmr_load = 1'b1;
                    tmr_val  = HOLD_LD;
                end
            end
            ST_HOLD: begin
                if (tmr_expired) state_d = ST_DONE;
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Outputs decoded from the state register
    always_comb begin
        busy     = 1'b1;
        done     = 1'b0;
        ide_rd_n = 1'b1;
        ide_wr_n = 1'b1;
        drive_en = 1'b0;
        addr_en  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy = 1'b0;
            end
            ST_TURN: begin
                drive_en = lat_write_q;
            end
            ST_SETUP, ST_HOLD: begin
                drive_en = lat_write_q;
                addr_en  = 1'b1;
            end
            ST_STROBE: begin
                drive_en = lat_write_q;
                addr_en  = 1'b1;
                ide_rd_n = lat_write_q;
                ide_wr_n = !lat_write_q;
            end
            ST_DONE: begin
                done = 1'b1;
            end
            default: begin
                busy = 1'b0;
            end
        endcase
        ide_cs_n = addr_en ? lat_cs_n_q : CS_IDLE;
        ide_addr = addr_en ? lat_addr_q : 3'b000;
    end

    // Request latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_write_q <= 1'b0;
            lat_wide_q  <= 1'b0;
            lat_cs_n_q  <= CS_IDLE;
            lat_addr_q  <= '0;
            lat_wdata_q <= '0;
        end else if (accept) begin
            lat_write_q <= req_write;
            lat_wide_q  <= wide_allowed(req_wide, req_cs_n, req_addr);
            lat_cs_n_q  <= req_cs_n;
            lat_addr_q  <= req_addr;
            lat_wdata_q <= req_wdata;
        end
    end

    // Read capture on the final strobe-low cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (capture && !lat_write_q) begin
            rdata_q <= rd_word;
        end
    end

    assign rdata = rdata_q;

    ide_pio_timer #(
        .CNT_W (CNT_W)
    ) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    ide_pio_lanes #(
        .DW (DW)
    ) lanes_i (
        .is_wide  (lat_wide_q),
        .drive_en (drive_en),
        .wdata    (lat_wdata_q),
        .bus_in   (ide_dd_in),
        .bus_out  (ide_dd_out),
        .oe_lo    (ide_dd_oe_lo),
        .oe_hi    (ide_dd_oe_hi),
        .rd_word  (rd_word)
    );

endmodule

// File: rtl/ide_pio_engine_chk.sv
module ide_pio_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       done,
    input logic [1:0] ide_cs_n,
    input logic [2:0] ide_addr,
    input logic       ide_rd_n,
    input logic       ide_wr_n,
    input logic       ide_dd_oe_lo,
    input logic       ide_dd_oe_hi
);

    logic strobe;
    assign strobe = !ide_rd_n || !ide_wr_n;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (ide_rd_n && ide_wr_n && ide_cs_n == 2'b11 && !ide_dd_oe_lo && !ide_dd_oe_hi)); // R1

    AST_BUSY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy); // R2

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ide_rd_n && !ide_wr_n)); // R3

    AST_RD_BUS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        !ide_rd_n |-> (!ide_dd_oe_lo && !ide_dd_oe_hi)); // R3

    AST_STROBE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> (ide_cs_n != 2'b11)); // R3

    AST_WR_BUS_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        !ide_wr_n |-> ide_dd_oe_lo); // R4

    AST_SEL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && $past(strobe)) |-> ($stable(ide_cs_n) && $stable(ide_addr))); // R6

    AST_HOLD_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ide_rd_n) |-> (ide_cs_n != 2'b11)); // R6

    AST_HOLD_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ide_wr_n) |-> (ide_cs_n != 2'b11 && ide_dd_oe_lo)); // R6

    AST_HI_LANE_DATA_REG: assert property (@(posedge clk) disable iff (!rst_n)
        (ide_dd_oe_hi && ide_cs_n != 2'b11) |-> (ide_cs_n == 2'b10 && ide_addr == 3'b000)); // R9

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10

    AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy); // R10

endmodule

bind ide_pio_engine ide_pio_engine_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .done         (done),
    .ide_cs_n     (ide_cs_n),
    .ide_addr     (ide_addr),
    .ide_rd_n     (ide_rd_n),
    .ide_wr_n     (ide_wr_n),
    .ide_dd_oe_lo (ide_dd_oe_lo),
    .ide_dd_oe_hi (ide_dd_oe_hi)
);

// File: tb/ide_pio_engine_tb.sv
module ide_pio_engine_tb_top;

    localparam int S = 3;
    localparam int W = 4;
    localparam int H = 2;
    localparam int LAT = 2 + S + W + H;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_wide = 1'b0;
    logic [1:0]  req_cs_n = 2'b11;
    logic [2:0]  req_addr = 3'b000;
    logic [15:0] req_wdata = 16'h0000;
    logic [15:0] ide_dd_in = 16'hDEAD;
    logic        busy, done, ide_rd_n, ide_wr_n, ide_dd_oe_lo, ide_dd_oe_hi;
    logic [15:0] rdata, ide_dd_out;
    logic [1:0]  ide_cs_n;
    logic [2:0]  ide_addr;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    ide_pio_engine #(
        .DW(16), .SETUP_CLKS(S), .STROBE_CLKS(W), .HOLD_CLKS(H)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_wide(req_wide), .req_cs_n(req_cs_n), .req_addr(req_addr),
        .req_wdata(req_wdata), .busy(busy), .done(done), .rdata(rdata),
        .ide_cs_n(ide_cs_n), .ide_addr(ide_addr), .ide_rd_n(ide_rd_n),
        .ide_wr_n(ide_wr_n), .ide_dd_out(ide_dd_out), .ide_dd_oe_lo(ide_dd_oe_lo),
        .ide_dd_oe_hi(ide_dd_oe_hi), .ide_dd_in(ide_dd_in)
    );

    // {write, wide, cs_n[1:0], addr[2:0], wdata, bus value, expected rdata, expected high-lane enable}
    localparam int NV = 7;
    localparam logic [55:0] VEC [NV] = '{
        {1'b1, 1'b1, 2'b10, 3'd0, 16'h1234, 16'h0000, 16'h0000, 1'b1},
        {1'b0, 1'b1, 2'b10, 3'd0, 16'h0000, 16'hA5C3, 16'hA5C3, 1'b0},
        {1'b1, 1'b0, 2'b10, 3'd3, 16'h12EF, 16'h0000, 16'h0000, 1'b0},
        {1'b0, 1'b1, 2'b10, 3'd7, 16'h0000, 16'h7E51, 16'h0051, 1'b0},
        {1'b0, 1'b0, 2'b01, 3'd6, 16'h0000, 16'hFF80, 16'h0080, 1'b0},
        {1'b1, 1'b1, 2'b01, 3'd6, 16'hABCD, 16'h0000, 16'h0000, 1'b0},
        {1'b0, 1'b0, 2'b10, 3'd0, 16'h0000, 16'h3C5A, 16'h005A, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic run_txn(input logic wr, input logic wide, input logic [1:0] cs,
                           input logic [2:0] ad, input logic [15:0] wd,
                           input logic [15:0] bus_val, input logic [15:0] exp_rd,
                           input logic exp_hi, input bit inject);
        int done_cyc = 0, busy_cnt = 0, done_cnt = 0;
        int setup_cnt = 0, strobe_cnt = 0, hold_cnt = 0;
        bit seen_strobe = 0, seen_rise = 0, bad_strobe = 0, rd_oe = 0;
        bit turn_ok = 0;
        logic [1:0] st_cs = 2'b11;
        logic [2:0] st_ad = 3'b111;
        logic [15:0] st_dd = 16'h0;
        logic st_hi = 1'b0;
        ide_dd_in = 16'hDEAD;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_wide = wide;
        req_cs_n = cs; req_addr = ad; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        for (int cyc = 1; cyc <= 40; cyc++) begin
            logic strobe_now;
            if (cyc > 1) @(negedge clk);
            if (inject && cyc == 3) begin
                req_valid = 1'b1; req_write = 1'b1; req_cs_n = 2'b01;
                req_addr = 3'd7; req_wdata = 16'h5555;
            end
            if (inject && cyc == 4) req_valid = 1'b0;
            strobe_now = wr ? !ide_wr_n : !ide_rd_n;
            if (wr ? !ide_rd_n : !ide_wr_n) bad_strobe = 1;
            if (!wr && (ide_dd_oe_lo || ide_dd_oe_hi)) rd_oe = 1;
            if (cyc == 1) turn_ok = (ide_dd_oe_lo == wr) && (ide_cs_n == 2'b11);
            if (busy) busy_cnt++;
            if (done) done_cnt++;
            if (strobe_now) begin
                if (!seen_strobe) begin
                    st_cs = ide_cs_n; st_ad = ide_addr;
                    ide_dd_in = bus_val;
                end
                st_dd = ide_dd_out; st_hi = ide_dd_oe_hi;
                seen_strobe = 1;
                strobe_cnt++;
            end else if (!seen_strobe && ide_cs_n != 2'b11) begin
                setup_cnt++;
            end else if (seen_strobe && ide_cs_n != 2'b11) begin
                if (!seen_rise) ide_dd_in = ~bus_val;
                seen_rise = 1;
                hold_cnt++;
            end
            if (done && done_cyc == 0) done_cyc = cyc;
            if (!busy && cyc > 1) break;
        end
        chk("R10 done latency", done_cyc, LAT);
        chk("R10 busy cycles", busy_cnt, LAT);
        chk("R10 done width", done_cnt, 1);
        chk("R5 strobe width", strobe_cnt, W);
        chk("R3 setup cycles", setup_cnt, S);
        chk("R6 hold cycles", hold_cnt, H);
        chk("R2 bus select", {st_cs, st_ad}, {cs, ad});
        chk("R3 other strobe idle", bad_strobe, 0);
        if (wr) begin
            chk("R4 direction before select", turn_ok, 1);
            chk("R4 low lane data", st_dd[7:0], wd[7:0]);
            chk("R9 high lane enable", st_hi, exp_hi);
            if (exp_hi) chk("R9 high lane data", st_dd[15:8], wd[15:8]);
        end else begin
            chk("R3 read leaves bus free", rd_oe, 0);
            chk("R7 R8 read result", rdata, exp_rd);
        end
        chk("R6 released after hold", {ide_cs_n, ide_dd_oe_lo, ide_dd_oe_hi}, {2'b11, 2'b00});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: state while reset is held
        chk("R1 reset strobes", {ide_rd_n, ide_wr_n}, 2'b11);
        chk("R1 reset selects", ide_cs_n, 2'b11);
        chk("R1 reset enables", {ide_dd_oe_lo, ide_dd_oe_hi}, 2'b00);
        chk("R1 reset busy done", {busy, done}, 2'b00);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 idle after reset", {busy, ide_rd_n, ide_wr_n, ide_cs_n}, 5'b01111);

        for (int i = 0; i < NV; i++) begin
            run_txn(VEC[i][55], VEC[i][54], VEC[i][53:52], VEC[i][51:49], VEC[i][48:33],
                    VEC[i][32:17], VEC[i][16:1], VEC[i][0], 1'b0);
        end

        // R2: request presented while busy is ignored
        run_txn(1'b0, 1'b1, 2'b10, 3'd0, 16'h0, 16'h9182, 16'h9182, 1'b0, 1'b1);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk("R2 no late access", {busy, ide_cs_n, ide_wr_n}, 4'b0111);
        end

        // R1: reset in the middle of a write strobe
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_wide = 1'b1;
        req_cs_n = 2'b10; req_addr = 3'd0; req_wdata = 16'hBEEF;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (1 + S) @(negedge clk);
        chk("R1 strobe active before abort", ide_wr_n, 1'b0);
        rst_n = 1'b0;
        #1;
        chk("R1 abort strobes", {ide_rd_n, ide_wr_n}, 2'b11);
        chk("R1 abort selects enables", {ide_cs_n, ide_dd_oe_lo, ide_dd_oe_hi, busy}, 5'b11000);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        run_txn(1'b0, 1'b0, 2'b10, 3'd1, 16'h0, 16'h4321, 16'h0021, 1'b0, 1'b0);

        summary();
    end

endmodule